// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits between a chip's pins and its core logic. Two power-down pins can each be armed by a configuration bit. While any armed pin is high, the unit freezes the whole boundary. The core keeps seeing the input values it had just before the freeze. Pin outputs and their enables keep their last values, so a pin that was high-impedance stays that way. The core clock is gated off, and every other input change is ignored. Keeper circuits are modelled as hold registers.

When every armed pin has gone low again, the unit stays frozen for a fixed wake-up interval counted in system-clock cycles, and only then resumes. A ready flag marks the cycles in which the boundary is live. A power-down pin whose arming bit is set no longer acts as a logic input: the core reads a constant zero for it. A pin that is not armed passes to the core like any other input and is frozen like any other input.

Top module: `pdn_hold_unit`

## Requirements
- R1: A power-down request exists in a cycle exactly when some power-down pin is high while its arming bit is 1. High pins whose arming bit is 0 cause no freeze. On the first rising edge that samples a request, `wake_ready` goes low.
- R2: When no request is pending and the unit is awake, each rising edge copies `pin_in` to `core_in`, so the latency is one cycle. From the first edge that samples a request, `core_in` holds the value captured before that edge, and changes on `pin_in` are ignored.
- R3: During the freeze, `pin_out` keeps the last `core_out` value captured before the request, whatever `core_out` does.
- R4: During the freeze, `pin_oe` keeps its last captured value (1 = driven, 0 = high-impedance). A pin that was high-impedance therefore stays high-impedance.
- R5: Bit i of `core_pd_in` reads 0 whenever bit i of `pd_en` is 1. When the arming bit is 0, that bit carries the registered pin level and is frozen together with the other inputs.
- R6: After the request drops, the unit stays frozen with `wake_ready` low for WAKE_CYCLES rising edges. On the WAKE_CYCLES-th consecutive edge without a request, `wake_ready` rises and live values are captured on that same edge.
- R7: A request that returns during the wake-up interval restarts the full interval of R6.
- R8: `core_clk_en` is updated only on falling clock edges and takes the value `wake_ready` had at that time. `core_clk` is `clk` ANDed with `core_clk_en`, so it starts and stops only during the low phase.
- R9: A synchronous reset clears `core_in`, `core_pd_in`, `pin_out`, `pin_oe`, `wake_ready` and `core_clk_en`. The first edge after reset with no request sets `wake_ready` and captures live values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the wake-up interval |
| rst | input | 1 | Synchronous active-high reset |
| pd_pin | input | 2 | Raw levels of the two power-down pins |
| pd_en | input | 2 | Arming bits, one for each power-down pin |
| pin_in | input | N_IN | Raw input pins |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core |
| core_in | output | N_IN | Held input values seen by the core |
| core_pd_in | output | 2 | Logic values of the power-down pins as seen by the core |
| core_clk | output | 1 | Gated core clock |
| core_clk_en | output | 1 | Clock gate enable, updated on the falling edge |
| pin_out | output | N_OUT | Held output data driven to the pins |
| pin_oe | output | N_OUT | Held output enables driven to the pins |
| wake_ready | output | 1 | High while the boundary is live |

## Verification
A wake-up counter in the wrong state makes `wake_ready` rise one or more edges early or late after a release. The edge-by-edge sweep through the interval catches this, including the case where a request returns in the middle of the interval. A hold register that fails to hold shows on `core_in`, `pin_out` or `pin_oe` at the first sample after the request edge, because the bench changes every input at that moment. A wrong clock-gate phase or a stale gate enable shows on `core_clk_en` at the first low phase after the freeze or after the wake-up.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  localparam int NUM_PD_PINS = 2;

  // A request exists when any armed power-down pin is high.
  function automatic logic pd_request(input logic [NUM_PD_PINS-1:0] pins,
                                      input logic [NUM_PD_PINS-1:0] armed);
    return |(pins & armed);
  endfunction
endpackage

// File: rtl/pdh_hold_reg.sv
module pdh_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/pdh_wake_ctl.sv
module pdh_wake_ctl #(
  parameter int WAKE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic hold,
  output logic ready
);
  localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WAKE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign hold = req || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else begin
      if (req)              cnt_q <= LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      ready <= !hold;
    end
  end
endmodule

// File: rtl/pdh_clk_gate.sv
module pdh_clk_gate (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic gate_en,
  output logic gclk
);
  // The enable changes only while clk is low, so gclk has no runt pulse.
  always_ff @(negedge clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= run;
  end

  assign gclk = clk & gate_en;
endmodule

// File: rtl/pdn_hold_unit.sv
module pdn_hold_unit #(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 8,
  parameter int WAKE_CYCLES = 20
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [pdh_pkg::NUM_PD_PINS-1:0]     pd_pin,
  input  logic [pdh_pkg::NUM_PD_PINS-1:0]     pd_en,
  input  logic [N_IN-1:0]                     pin_in,
  input  logic [N_OUT-1:0]                    core_out,
  input  logic [N_OUT-1:0]                    core_oe,
  output logic [N_IN-1:0]                     core_in,
  output logic [pdh_pkg::NUM_PD_PINS-1:0]     core_pd_in,
  output logic                                core_clk,
  output logic                                core_clk_en,
  output logic [N_OUT-1:0]                    pin_out,
  output logic [N_OUT-1:0]                    pin_oe,
  output logic                                wake_ready
);
  localparam int NPD = pdh_pkg::NUM_PD_PINS;

  logic           req;
  logic           hold;
  logic [NPD-1:0] pd_held;

  assign req = pdh_pkg::pd_request(pd_pin, pd_en);

  pdh_wake_ctl #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .req(req), .hold(hold), .ready(wake_ready)
  );

  pdh_hold_reg #(.WIDTH(N_IN)) u_in_hold (
    .clk(clk), .rst(rst), .hold(hold), .d(pin_in), .q(core_in)
  );

  pdh_hold_reg #(.WIDTH(N_OUT)) u_out_hold (
    .clk(clk), .rst(rst), .hold(hold), .d(core_out), .q(pin_out)
  );

  pdh_hold_reg #(.WIDTH(N_OUT)) u_oe_hold (
    .clk(clk), .rst(rst), .hold(hold), .d(core_oe), .q(pin_oe)
  );

  pdh_hold_reg #(.WIDTH(NPD)) u_pd_hold (
    .clk(clk), .rst(rst), .hold(hold), .d(pd_pin), .q(pd_held)
  );

  // An armed pin leaves the logic path and reads as constant zero.
  for (genvar i = 0; i < NPD; i++) begin : g_pd_mask
    assign core_pd_in[i] = pd_en[i] ? 1'b0 : pd_held[i];
  end

  pdh_clk_gate u_gate (
    .clk(clk), .rst(rst), .run(wake_ready), .gate_en(core_clk_en), .gclk(core_clk)
  );
endmodule

// File: rtl/pdn_hold_unit_chk.sv
module pdn_hold_unit_chk #(
  parameter int N_IN        = 8,
  parameter int N_OUT       = 8,
  parameter int WAKE_CYCLES = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       pd_pin,
  input logic [1:0]       pd_en,
  input logic [N_IN-1:0]  core_in,
  input logic [1:0]       core_pd_in,
  input logic             core_clk_en,
  input logic [N_OUT-1:0] pin_out,
  input logic [N_OUT-1:0] pin_oe,
  input logic             wake_ready
);
  localparam int KW = $clog2(WAKE_CYCLES + 1);
  localparam logic [KW-1:0] SAT = KW'(WAKE_CYCLES);

  logic          pd_req;
  logic [KW-1:0] since_rel;

  assign pd_req = |(pd_pin & pd_en);

  // Counts the rising edges since the last request, saturating at WAKE_CYCLES.
  always_ff @(posedge clk) begin
    if (rst)                   since_rel <= SAT;
    else if (pd_req)           since_rel <= '0;
    else if (since_rel != SAT) since_rel <= since_rel + 1'b1;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    pd_req |=> !wake_ready);
  a_r2_inputs_frozen: assert property (@(posedge clk) disable iff (rst)
    pd_req |=> $stable(core_in));
  a_r3_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    pd_req |=> $stable(pin_out));
  a_r4_enables_frozen: assert property (@(posedge clk) disable iff (rst)
    pd_req |=> $stable(pin_oe));

  always_comb begin
    a_r5_armed_reads_zero: assert (rst || ((core_pd_in & pd_en) == 2'b00));
  end

  // R6 and R7: ready stays low until WAKE_CYCLES request-free edges have passed.
  a_r6_no_early_wake: assert property (@(posedge clk) disable iff (rst)
    (since_rel != SAT) |-> !wake_ready);
  a_r6_wake_on_time: assert property (@(posedge clk) disable iff (rst)
    ((since_rel == SAT) && ($past(since_rel) == SAT - 1'b1)) |-> wake_ready);
  a_r8_gate_follows_ready: assert property (@(posedge clk) disable iff (rst)
    core_clk_en == wake_ready);
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!wake_ready && core_in == '0 && pin_oe == '0));
endmodule

bind pdn_hold_unit pdn_hold_unit_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .pd_pin(pd_pin), .pd_en(pd_en), .core_in(core_in),
  .core_pd_in(core_pd_in), .core_clk_en(core_clk_en), .pin_out(pin_out),
  .pin_oe(pin_oe), .wake_ready(wake_ready)
);

// File: tb/pdn_hold_unit_test.sv
module pdn_hold_unit_test;
  localparam int CLK_P = 10;
  localparam int WAKE  = 6;
  localparam int NV    = 6;

  typedef struct packed {
    logic [1:0] pd;
    logic [1:0] en;
    logic [7:0] din;
    logic [7:0] dout;
    logic [7:0] doe;
    logic [7:0] e_in;
    logic [7:0] e_out;
    logic [7:0] e_oe;
    logic [1:0] e_pd;
    logic       e_rdy;
  } vec_t;

  // Rows run in sequence; each row is applied for one rising edge.
  localparam vec_t TABLE [NV] = '{
    '{2'b00, 2'b11, 8'hA5, 8'h3C, 8'hFF, 8'hA5, 8'h3C, 8'hFF, 2'b00, 1'b1},
    '{2'b00, 2'b01, 8'h5A, 8'hC3, 8'h0F, 8'h5A, 8'hC3, 8'h0F, 2'b00, 1'b1},
    '{2'b11, 2'b00, 8'h77, 8'h66, 8'h55, 8'h77, 8'h66, 8'h55, 2'b11, 1'b1},
    '{2'b10, 2'b01, 8'h11, 8'h22, 8'hF0, 8'h11, 8'h22, 8'hF0, 2'b10, 1'b1},
    '{2'b01, 2'b01, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h22, 8'hF0, 2'b10, 1'b0},
    '{2'b11, 2'b11, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 8'hF0, 2'b00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pd_pin = 2'b00, pd_en = 2'b00;
  logic [7:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic [7:0] core_in, pin_out, pin_oe;
  logic [1:0] core_pd_in;
  logic       core_clk, core_clk_en, wake_ready;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pdn_hold_unit #(.N_IN(8), .N_OUT(8), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst(rst), .pd_pin(pd_pin), .pd_en(pd_en), .pin_in(pin_in),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .core_pd_in(core_pd_in), .core_clk(core_clk), .core_clk_en(core_clk_en),
    .pin_out(pin_out), .pin_oe(pin_oe), .wake_ready(wake_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    pin_in = 8'hEE; core_out = 8'hDD; core_oe = 8'hCC;
    repeat (3) tick();
    chk("R9 core_in", core_in, 0);
    chk("R9 pin_out", pin_out, 0);
    chk("R9 pin_oe", pin_oe, 0);
    chk("R9 ready", wake_ready, 0);
    chk("R9 clk_en", core_clk_en, 0);
    rst = 1'b0;
    tick();
    chk("R9 first edge ready", wake_ready, 1);
    chk("R9 first edge capture", core_in, 8'hEE);

    // R1..R5 from the table
    for (int i = 0; i < NV; i++) begin
      pd_pin = TABLE[i].pd; pd_en = TABLE[i].en; pin_in = TABLE[i].din;
      core_out = TABLE[i].dout; core_oe = TABLE[i].doe;
      tick();
      chk("R1 ready", wake_ready, TABLE[i].e_rdy);
      chk("R2 core_in", core_in, TABLE[i].e_in);
      chk("R3 pin_out", pin_out, TABLE[i].e_out);
      chk("R4 pin_oe", pin_oe, TABLE[i].e_oe);
      chk("R5 core_pd_in", core_pd_in, TABLE[i].e_pd);
    end
    chk("R8 gate off in freeze", core_clk_en, 0);

    // R6: exact wake-up edge
    pd_pin = 2'b00; pd_en = 2'b01;
    pin_in = 8'h9A; core_out = 8'hBC; core_oe = 8'h3C;
    for (int j = 1; j <= WAKE; j++) begin
      tick();
      if (j < WAKE) begin
        chk("R6 ready low", wake_ready, 0);
        chk("R6 input held", core_in, 8'h11);
        chk("R8 gate still off", core_clk_en, 0);
      end else begin
        chk("R6 ready on time", wake_ready, 1);
        chk("R6 live input", core_in, 8'h9A);
        chk("R6 live output", pin_out, 8'hBC);
        chk("R6 live enable", pin_oe, 8'h3C);
      end
    end
    #(CLK_P/2);
    chk("R8 gate on after low phase", core_clk_en, 1);

    // R7: request during wake-up restarts the interval
    pd_pin = 2'b01;
    tick();
    chk("R7 enter", wake_ready, 0);
    pd_pin = 2'b00; pin_in = 8'h42;
    repeat (3) tick();
    chk("R7 mid wake", wake_ready, 0);
    pd_pin = 2'b01;
    tick();
    chk("R7 re-request", wake_ready, 0);
    pd_pin = 2'b00;
    for (int j = 1; j <= WAKE; j++) begin
      tick();
      if (j < WAKE) chk("R7 restarted count", wake_ready, 0);
      else begin
        chk("R7 ready after full interval", wake_ready, 1);
        chk("R7 live input", core_in, 8'h42);
      end
    end
    finish_run();
  end
endmodule